// File: doc/BRIEF.md
# Write Leveling Delay Search Engine

This block is a hardware sequencer that finds the write-DQS delay for nine byte lanes at once. After a start pulse it places the memory PHY in write leveling mode and runs a loop of handshakes with it. Each round waits for the PHY to signal readiness, sends a one-cycle request, waits for the done indication and then samples one response bit per lane. Every lane that sees a low response moves its 7-bit delay up by one. A lane that sees a high response stops and keeps its delay. Lanes that have finished hold still while the others go on searching.

Once every lane has finished, the mode output returns to zero and the complete flag is raised. Each lane also presents settings derived from its delay. The first is a flag that is set when the DQS delay is in the lower half of the cycle. The second is a write-data delay, placed a quarter cycle earlier than the DQS delay and wrapping modulo 128. The third is a half-cycle flag for that write-data delay.

A lane whose response is already high on the first sample is flagged as an error. A lane that reaches the top delay value without ever seeing a high response is flagged as a timeout.

Top module: `wrlvl_engine`

## Requirements
- R1: After reset, busy, complete, lvl_req and lvl_mode are 0, all delays are 0 and all lane flags are 0.
- R2: A start pulse while idle makes busy 1 and lvl_mode 2'b01 (write leveling) until the run ends, after which lvl_mode returns to 2'b00. A start pulse while busy has no effect.
- R3: lvl_req is a single-cycle pulse that is raised only in the cycle after phy_ready was seen high. Responses are sampled only in a cycle where phy_done is high after a request.
- R4: Each lane's delay (lane i at dqs_dly[7i+6:7i]) starts at 0 and increases by exactly 1 after each sample in which that lane's response bit is 0.
- R5: A lane stops when it samples a response of 1 and holds its delay, while the other lanes keep stepping.
- R6: A lane whose response is 1 on its first sample of a run sets its lvl_err bit, and its delay stays at 0.
- R7: A lane that samples 0 at delay 0x7F stops at 0x7F and sets its lvl_tout bit.
- R8: dqs_lt_half[i] is 1 exactly when lane i's delay is below 0x40.
- R9: wrdata_dly for a lane is the delay minus 0x20 when the delay is above 0x20, and otherwise the delay plus 0x60 modulo 128. A delay of 0x20 therefore gives 0x00.
- R10: wrdata_lt_half[i] is 1 exactly when lane i's write-data delay is below 0x40.
- R11: complete rises once every lane has finished. At that moment busy falls, and complete is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a leveling run (accepted when idle) |
| phy_ready | input | 1 | PHY can accept a leveling request |
| phy_done | input | 1 | PHY finished the current request |
| phy_resp | input | 9 | Per-lane leveling response |
| lvl_mode | output | 2 | Leveling mode: 01 write leveling, 00 off |
| lvl_req | output | 1 | One-cycle leveling request |
| busy | output | 1 | Run in progress |
| complete | output | 1 | Last run finished |
| dqs_dly | output | 63 | Per-lane write-DQS delay, 7 bits each |
| dqs_lt_half | output | 9 | DQS delay below half cycle |
| wrdata_dly | output | 63 | Per-lane write-data delay, 7 bits each |
| wrdata_lt_half | output | 9 | Write-data delay below half cycle |
| lvl_err | output | 9 | Response high on first sample |
| lvl_tout | output | 9 | No high response up to 0x7F |

## Verification
The hardest situation to reach is the one where lanes finish at very different delays. In one run, some lanes must stop on the first sample, some must step through the full range to a timeout, and the rest must stop in between while the others keep going. The bench contains a PHY model that answers each lane high once that lane's driven delay reaches its own threshold. A table of nine-lane threshold sets places lanes at 0, at the wrap point 0x20, around the half-cycle boundaries and past 0x7F in the same run. A directed test holds phy_ready low to confirm that no request goes out and no lane moves.

// File: rtl/wrlvl_pkg.sv
// Shared types for the write leveling engine.
// Assumes: consumers import this package before declaring state registers.
package wrlvl_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT_RDY,
        SQ_REQ,
        SQ_WAIT_DONE,
        SQ_CHECK
    } seq_state_t;

    localparam logic [1:0] MODE_OFF   = 2'b00;
    localparam logic [1:0] MODE_WRLVL = 2'b01;
endpackage

// File: rtl/wrlvl_seq.sv
// Handshake sequencer: runs the ready / request / done loop toward the PHY
// and issues a clear at run start and a sample strobe per finished request.
// Assumes: phy_done is only meaningful after a request has been sent.
module wrlvl_seq
    import wrlvl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       phy_ready,
    input  logic       phy_done,
    input  logic       all_done,
    output logic [1:0] lvl_mode,
    output logic       lvl_req,
    output logic       busy,
    output logic       complete,
    output logic       clr,
    output logic       sample
);
    seq_state_t state_q, state_d;
    logic       complete_q;

    assign clr      = (state_q == SQ_IDLE) && start;
    assign sample   = (state_q == SQ_WAIT_DONE) && phy_done;
    assign lvl_req  = (state_q == SQ_REQ);
    assign busy     = (state_q != SQ_IDLE);
    assign lvl_mode = busy ? MODE_WRLVL : MODE_OFF;
    assign complete = complete_q;

    // Next-state selection for the handshake loop.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:      if (start) state_d = SQ_WAIT_RDY;
            SQ_WAIT_RDY:  if (phy_ready) state_d = SQ_REQ;
            SQ_REQ:       state_d = SQ_WAIT_DONE;
            SQ_WAIT_DONE: if (phy_done) state_d = SQ_CHECK;
            SQ_CHECK:     state_d = all_done ? SQ_IDLE : SQ_WAIT_RDY;
            default:      state_d = SQ_IDLE;
        endcase
    end

    // State and completion flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            complete_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clr)
                complete_q <= 1'b0;
            else if (state_q == SQ_CHECK && all_done)
                complete_q <= 1'b1;
        end
    end

    AST_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_req) |-> $past(phy_ready)); // R3
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_req |=> !lvl_req); // R3
    AST_MODE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lvl_mode == MODE_WRLVL); // R2
    AST_MODE_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(complete) |-> (lvl_mode == MODE_OFF && !busy)); // R11
endmodule

// File: rtl/wrlvl_lane.sv
// One byte lane's linear delay search plus its derived delay settings.
// Assumes: clr and sample never coincide; sample arrives once per request.
module wrlvl_lane #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sample,
    input  logic             resp,
    output logic [DLY_W-1:0] dly,
    output logic             done,
    output logic             err,
    output logic             tout,
    output logic             dqs_lt_half,
    output logic [DLY_W-1:0] wr_dly,
    output logic             wr_lt_half
);
    localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};
    localparam logic [DLY_W-1:0] HALF    = DLY_W'(1) << (DLY_W - 1);
    localparam logic [DLY_W-1:0] QTR     = DLY_W'(1) << (DLY_W - 2);
    localparam logic [DLY_W-1:0] THREEQ  = HALF + QTR;

    logic             active_q, first_q, err_q, tout_q;
    logic [DLY_W-1:0] dly_q;

    // Search step: clear on run start, then step or stop on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            first_q  <= 1'b0;
            err_q    <= 1'b0;
            tout_q   <= 1'b0;
            dly_q    <= '0;
        end else if (clr) begin
            active_q <= 1'b1;
            first_q  <= 1'b1;
            err_q    <= 1'b0;
            tout_q   <= 1'b0;
            dly_q    <= '0;
        end else if (sample && active_q) begin
            first_q <= 1'b0;
            if (resp) begin
                active_q <= 1'b0;
                err_q    <= first_q;
            end else if (dly_q == DLY_MAX) begin
                active_q <= 1'b0;
                tout_q   <= 1'b1;
            end else begin
                dly_q <= dly_q + 1'b1;
            end
        end
    end

    // Derived settings: quarter-cycle earlier data delay with wrap.
    always_comb begin
        wr_dly      = (dly_q > QTR) ? dly_q - QTR : dly_q + THREEQ;
        dqs_lt_half = dly_q < HALF;
        wr_lt_half  = wr_dly < HALF;
    end

    assign dly  = dly_q;
    assign done = !active_q;
    assign err  = err_q;
    assign tout = tout_q;

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && active_q && !resp && dly_q != DLY_MAX && !clr)
        |=> dly_q == $past(dly_q) + 1'b1); // R4
    AST_HOLD_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && !clr) |=> $stable(dly_q)); // R5
    AST_ERR_TOUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_q && tout_q)); // R6
    AST_TOUT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        tout_q |-> dly_q == DLY_MAX); // R7
endmodule

// File: rtl/wrlvl_engine.sv
// Top of the write leveling engine: one sequencer shared by N_LANES
// independent lane searches, with the outputs packed per lane.
// Assumes: phy_resp is stable whenever phy_done is high.
module wrlvl_engine #(
    parameter int N_LANES = 9,
    parameter int DLY_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     phy_ready,
    input  logic                     phy_done,
    input  logic [N_LANES-1:0]       phy_resp,
    output logic [1:0]               lvl_mode,
    output logic                     lvl_req,
    output logic                     busy,
    output logic                     complete,
    output logic [N_LANES*DLY_W-1:0] dqs_dly,
    output logic [N_LANES-1:0]       dqs_lt_half,
    output logic [N_LANES*DLY_W-1:0] wrdata_dly,
    output logic [N_LANES-1:0]       wrdata_lt_half,
    output logic [N_LANES-1:0]       lvl_err,
    output logic [N_LANES-1:0]       lvl_tout
);
    logic                clr, sample;
    logic [N_LANES-1:0]  lane_done;

    wrlvl_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .phy_ready (phy_ready),
        .phy_done  (phy_done),
        .all_done  (&lane_done),
        .lvl_mode  (lvl_mode),
        .lvl_req   (lvl_req),
        .busy      (busy),
        .complete  (complete),
        .clr       (clr),
        .sample    (sample)
    );

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        wrlvl_lane #(.DLY_W(DLY_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr         (clr),
            .sample      (sample),
            .resp        (phy_resp[i]),
            .dly         (dqs_dly[i*DLY_W +: DLY_W]),
            .done        (lane_done[i]),
            .err         (lvl_err[i]),
            .tout        (lvl_tout[i]),
            .dqs_lt_half (dqs_lt_half[i]),
            .wr_dly      (wrdata_dly[i*DLY_W +: DLY_W]),
            .wr_lt_half  (wrdata_lt_half[i])
        );
    end
endmodule

// File: tb/test_wrlvl_engine.sv
module test_wrlvl_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 9;
    localparam int NCASE = 4;
    localparam logic [7:0] CASES [NCASE][NL] = '{
        '{8'h01, 8'h20, 8'h21, 8'h3F, 8'h40, 8'h5F, 8'h60, 8'h61, 8'h7F},
        '{8'h00, 8'h80, 8'h10, 8'h20, 8'h41, 8'h00, 8'h7E, 8'h30, 8'h50},
        '{8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05, 8'h05},
        '{8'h1F, 8'h22, 8'h3A, 8'h44, 8'h66, 8'h02, 8'h80, 8'h71, 8'h0B}
    };

    logic clk = 0, rst_n = 0, start = 0, phy_ready = 0, phy_done = 0;
    logic [NL-1:0] phy_resp;
    logic [1:0] lvl_mode;
    logic lvl_req, busy, complete;
    logic [NL*7-1:0] dqs_dly, wrdata_dly;
    logic [NL-1:0] dqs_lt_half, wrdata_lt_half, lvl_err, lvl_tout;

    logic [7:0] thr [NL];
    logic ready_en = 1;
    logic req_seen = 0;
    int checks = 0, errors = 0, cyc = 0, pend = 0;

    wrlvl_engine i_wrlvl_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .phy_ready(phy_ready),
        .phy_done(phy_done), .phy_resp(phy_resp), .lvl_mode(lvl_mode),
        .lvl_req(lvl_req), .busy(busy), .complete(complete),
        .dqs_dly(dqs_dly), .dqs_lt_half(dqs_lt_half), .wrdata_dly(wrdata_dly),
        .wrdata_lt_half(wrdata_lt_half), .lvl_err(lvl_err), .lvl_tout(lvl_tout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: lane answers high once its delay reaches its threshold.
    always_comb
        for (int i = 0; i < NL; i++)
            phy_resp[i] = ({1'b0, dqs_dly[i*7 +: 7]} >= thr[i]);

    // PHY handshake model driven away from the active edge.
    initial forever begin
        @(negedge clk);
        cyc++;
        phy_ready = ready_en && cyc[0];
        if (lvl_req) begin req_seen = 1; pend = 3; end
        if (pend > 0) pend--;
        phy_done = (pend == 1);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_case(input int c);
        for (int i = 0; i < NL; i++) thr[i] = CASES[c][i];
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R2", "busy after start", busy, 1);
        chk("R2", "mode during run", lvl_mode, 2'b01);
        for (int k = 0; k < 5000 && !complete; k++) @(negedge clk);
        chk("R11", "complete", complete, 1);
        chk("R11", "busy at end", busy, 0);
        chk("R2", "mode at end", lvl_mode, 2'b00);
        for (int i = 0; i < NL; i++) begin
            int t = thr[i];
            int ed = (t == 0) ? 0 : (t > 8'h7F ? 8'h7F : t);
            int ew = (ed > 8'h20) ? ed - 8'h20 : ((ed + 8'h60) & 8'h7F);
            chk((t == 0) ? "R6" : (t > 8'h7F ? "R7" : "R5"), "dqs delay", dqs_dly[i*7 +: 7], ed);
            chk("R6", "err flag", lvl_err[i], t == 0);
            chk("R7", "timeout flag", lvl_tout[i], t > 8'h7F);
            chk("R8", "dqs half flag", dqs_lt_half[i], ed < 8'h40);
            chk("R9", "wrdata delay", wrdata_dly[i*7 +: 7], ew);
            chk("R10", "wrdata half flag", wrdata_lt_half[i], ew < 8'h40);
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < NL; i++) thr[i] = 8'h10;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "complete", complete, 0);
        chk("R1", "req", lvl_req, 0);
        chk("R1", "mode", lvl_mode, 0);
        chk("R1", "dqs", (dqs_dly == 0), 1);
        chk("R1", "flags", (lvl_err | lvl_tout), 0);
        rst_n = 1;
        @(negedge clk);

        // Table of threshold vectors, one run each.
        for (int c = 0; c < NCASE; c++) run_case(c);

        // R3: ready held low, so no request and no step.
        ready_en = 0; req_seen = 0;
        for (int i = 0; i < NL; i++) thr[i] = 8'h03;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk("R11", "complete cleared by start", complete, 0);
        repeat (20) @(negedge clk);
        chk("R3", "no request without ready", req_seen, 0);
        chk("R4", "no step without sample", (dqs_dly == 0), 1);
        // R2: start while busy is ignored
        start = 1; @(negedge clk); start = 0;
        chk("R2", "still busy", busy, 1);
        ready_en = 1;
        // R4: step by one per low sample
        for (int k = 0; k < 200 && dqs_dly[6:0] == 0; k++) @(negedge clk);
        chk("R4", "first step", dqs_dly[6:0], 1);
        chk("R3", "request sent with ready", req_seen, 1);
        for (int k = 0; k < 500 && !complete; k++) @(negedge clk);
        chk("R5", "lane 8 final", dqs_dly[8*7 +: 7], 3);
        chk("R11", "complete after run", complete, 1);
        finish_run();
    end
endmodule